// File: doc/BRIEF.md
# Floating-Point Special-Case Resolver

This block is the last stage of a binary64 arithmetic pipeline. It receives the two original operands, the 3-bit operation code, the 2-bit rounding mode, the already-rounded result from the arithmetic and rounding stages, and the two remainder bits left over by rounding. From these it decides whether the plain rounded result may leave the pipeline or whether a special value has to replace it. It then registers the final 64-bit word together with five status flags.

The operands are sorted into zero, infinity, quiet NaN and signalling NaN classes. A fixed priority encoder then picks one outcome: NaN handling, an invalid operand pairing, division by zero, an infinite operand, overflow or underflow of the rounded value, or a plain pass-through. When the outcome is an infinity and the rounding mode points away from it, the infinity is replaced by the largest finite value of the same sign. The block does no arithmetic of its own.

Top module: `fpx_special_resolver`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` and all outputs take the new value at that edge. When `in_valid` is low, `out_valid` goes low at the next edge and the result and flags hold their values.
- R2: If either operand is a signalling NaN, the result is the canonical quiet NaN 0x7FF8000000000000, and both invalid and exception are high. A signalling NaN has exponent all ones, fraction bit 51 at 0 and a nonzero fraction.
- R3: If either operand is a quiet NaN (exponent all ones, fraction bit 51 at 1) and neither is signalling, that operand is output bit for bit. Operand A wins when both are quiet NaNs. Exception is high and invalid is low.
- R4: With op codes 000 add, 001 subtract, 010 multiply and 011 divide, the pairs (+inf)+(-inf), (-inf)+(+inf), inf-inf of equal sign, 0*inf, inf*0, 0/0 and inf/inf produce the canonical signalling NaN 0x7FF4000000000000, with invalid and exception high. Op codes 1xx skip every operation-specific check.
- R5: A divide of a non-NaN, nonzero A by a zero B gives an infinity with the sign of A. Exception is high and overflow is low.
- R6: If an operand is infinite and no rule above applies, the result is an infinity. For add its sign is that of the infinite operand, A first. For subtract it is A's sign if A is infinite, otherwise the inverse of B's sign. For multiply and divide it is the XOR of both signs. A finite A divided by an infinite B instead gives a zero with A's sign and raises underflow. Exception is high in all of these cases.
- R7: If the rounded value has an all-ones exponent, the result is an infinity with the rounded value's sign, and overflow and exception are high.
- R8: If the rounded value is a zero and at least one remainder bit is set, the result is a zero with the rounded value's sign, and underflow and exception are high.
- R9: Rounding mode codes are 00 nearest even, 01 toward zero, 10 toward +inf and 11 toward -inf. An infinity result that is positive under modes 01 or 11, or negative under modes 01 or 10, becomes the largest finite value of that sign: exponent 2046 and fraction all ones.
- R10: Inexact equals the OR of the two remainder bits in every case. It does not raise exception by itself.
- R11: When no special case applies, the rounded value passes unchanged, and exception, invalid, overflow and underflow are low.
- R12: The outcome is chosen in this order: signalling NaN, quiet NaN, invalid pairing, divide by zero, infinite operand, overflow, underflow, pass-through.
- R13: While reset is asserted and until the first valid input, `out_valid`, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Inputs are valid and are captured at this edge |
| op_code | input | 3 | Operation: 000 add, 001 subtract, 010 multiply, 011 divide |
| round_mode | input | 2 | Rounding mode, encoded as in R9 |
| opnd_a | input | 64 | Original operand A |
| opnd_b | input | 64 | Original operand B |
| rnd_value | input | 64 | Rounded result from the rounding stage |
| rnd_rem | input | 2 | Remainder bits dropped by rounding |
| out_valid | output | 1 | Result and flags were updated at the last edge |
| result | output | 64 | Final binary64 result |
| flag_underflow | output | 1 | Underflow status |
| flag_overflow | output | 1 | Overflow status |
| flag_inexact | output | 1 | Inexact status |
| flag_exception | output | 1 | Some special case applied |
| flag_invalid | output | 1 | Invalid operation |

## Verification
Every result and flag is due exactly one rising edge after the edge that sees `in_valid` high, and is then held. The bench drives each input set on a falling edge, pulls `in_valid` low at the next falling edge, and reads the registered outputs at that same falling edge, half a cycle after the capturing edge. Checks that an idle cycle holds the outputs read them one full cycle later, again on a falling edge.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  // Classification of one binary64 word
  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic qnan;
    logic snan;
  } fpx_class_t;

  // Resolved outcome, listed in falling priority after CS_NORMAL
  typedef enum logic [2:0] {
    CS_NORMAL  = 3'd0,
    CS_SNAN    = 3'd1,
    CS_QNAN    = 3'd2,
    CS_INVALID = 3'd3,
    CS_DIVZERO = 3'd4,
    CS_INFOP   = 3'd5,
    CS_OVF     = 3'd6,
    CS_UNF     = 3'd7
  } fpx_case_e;

  typedef struct packed {
    logic underflow;
    logic overflow;
    logic invalid;
    logic exception;
  } fpx_flags_t;

  localparam logic [1:0] OPL_ADD = 2'b00;
  localparam logic [1:0] OPL_SUB = 2'b01;
  localparam logic [1:0] OPL_MUL = 2'b10;
  localparam logic [1:0] OPL_DIV = 2'b11;

  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_ZERO = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;
  localparam logic [1:0] RM_DOWN = 2'b11;

endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] value,
  output fpx_class_t            cls
);
  localparam int SIGN_POS = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_ones, exp_zero, frac_zero;

  always_comb begin
    exp_f     = value[FRAC_W +: EXP_W];
    frac_f    = value[FRAC_W-1:0];
    exp_ones  = &exp_f;
    exp_zero  = ~|exp_f;
    frac_zero = ~|frac_f;
    cls.sign  = value[SIGN_POS];
    cls.zero  = exp_zero & frac_zero;
    cls.inf   = exp_ones & frac_zero;
    cls.qnan  = exp_ones & frac_f[FRAC_W-1];
    cls.snan  = exp_ones & ~frac_f[FRAC_W-1] & ~frac_zero;
  end
endmodule

// File: rtl/fpx_case_select.sv
module fpx_case_select
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  fpx_class_t                ca,
  input  fpx_class_t                cb,
  input  logic [2:0]                op,
  input  logic [EXP_W+FRAC_W-1:0]   res_mag,
  input  logic                      rem_nz,
  output fpx_case_e                 sel
);
  logic arith, is_add, is_sub, is_mul, is_div;
  logic bad_pair, res_exp_ones, res_zero;

  always_comb begin
    arith  = ~op[2];
    is_add = arith & (op[1:0] == OPL_ADD);
    is_sub = arith & (op[1:0] == OPL_SUB);
    is_mul = arith & (op[1:0] == OPL_MUL);
    is_div = arith & (op[1:0] == OPL_DIV);

    bad_pair = (is_add & ca.inf & cb.inf & (ca.sign != cb.sign))
             | (is_sub & ca.inf & cb.inf & (ca.sign == cb.sign))
             | (is_mul & ((ca.zero & cb.inf) | (ca.inf & cb.zero)))
             | (is_div & ((ca.zero & cb.zero) | (ca.inf & cb.inf)));

    res_exp_ones = &res_mag[FRAC_W +: EXP_W];
    res_zero     = ~|res_mag;

    if (ca.snan || cb.snan)             sel = CS_SNAN;
    else if (ca.qnan || cb.qnan)        sel = CS_QNAN;
    else if (bad_pair)                  sel = CS_INVALID;
    else if (is_div && cb.zero)         sel = CS_DIVZERO;
    else if (arith && (ca.inf || cb.inf)) sel = CS_INFOP;
    else if (res_exp_ones)              sel = CS_OVF;
    else if (res_zero && rem_nz)        sel = CS_UNF;
    else                                sel = CS_NORMAL;
  end
endmodule

// File: rtl/fpx_result_build.sv
module fpx_result_build
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  fpx_case_e                 sel,
  input  logic [1:0]                op_lo,
  input  logic [1:0]                rmode,
  input  logic [EXP_W+FRAC_W:0]     opa,
  input  logic [EXP_W+FRAC_W:0]     opb,
  input  logic [EXP_W+FRAC_W:0]     rnd,
  input  logic                      a_qnan,
  input  logic                      a_inf,
  output logic [EXP_W+FRAC_W:0]     res,
  output fpx_flags_t                flags
);
  localparam int W  = EXP_W + FRAC_W + 1;
  localparam int SP = W - 1;
  localparam logic [W-1:0] QNAN_C =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] SNAN_C =
    {1'b0, {EXP_W{1'b1}}, 2'b01, {(FRAC_W-2){1'b0}}};
  localparam logic [EXP_W-1:0] EXP_MAXFIN = {{(EXP_W-1){1'b1}}, 1'b0};

  logic make_inf, inf_sign, saturate;
  logic sa, sb;
  logic [W-1:0] pre_res;

  always_comb begin
    sa       = opa[SP];
    sb       = opb[SP];
    make_inf = 1'b0;
    inf_sign = 1'b0;
    pre_res  = rnd;
    flags    = '0;

    unique case (sel)
      CS_SNAN: begin
        pre_res         = QNAN_C;
        flags.invalid   = 1'b1;
        flags.exception = 1'b1;
      end
      CS_QNAN: begin
        pre_res         = a_qnan ? opa : opb;
        flags.exception = 1'b1;
      end
      CS_INVALID: begin
        pre_res         = SNAN_C;
        flags.invalid   = 1'b1;
        flags.exception = 1'b1;
      end
      CS_DIVZERO: begin
        make_inf        = 1'b1;
        inf_sign        = sa;
        flags.exception = 1'b1;
      end
      CS_INFOP: begin
        flags.exception = 1'b1;
        make_inf        = 1'b1;
        unique case (op_lo)
          OPL_ADD: inf_sign = a_inf ? sa : sb;
          OPL_SUB: inf_sign = a_inf ? sa : ~sb;
          OPL_MUL: inf_sign = sa ^ sb;
          default: begin
            if (a_inf) begin
              inf_sign = sa ^ sb;
            end else begin
              make_inf        = 1'b0;
              pre_res         = {sa, {(W-1){1'b0}}};
              flags.underflow = 1'b1;
            end
          end
        endcase
      end
      CS_OVF: begin
        make_inf        = 1'b1;
        inf_sign        = rnd[SP];
        flags.overflow  = 1'b1;
        flags.exception = 1'b1;
      end
      CS_UNF: begin
        pre_res         = {rnd[SP], {(W-1){1'b0}}};
        flags.underflow = 1'b1;
        flags.exception = 1'b1;
      end
      default: pre_res = rnd;
    endcase

    // Directed modes that point away from the infinity clamp it
    saturate = (rmode == RM_ZERO)
             | (~inf_sign & (rmode == RM_DOWN))
             | ( inf_sign & (rmode == RM_UP));

    if (make_inf) begin
      if (saturate) res = {inf_sign, EXP_MAXFIN, {FRAC_W{1'b1}}};
      else          res = {inf_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      res = pre_res;
    end
  end
endmodule

// File: rtl/fpx_special_resolver.sv
module fpx_special_resolver
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int REM_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              op_code,
  input  logic [1:0]              round_mode,
  input  logic [EXP_W+FRAC_W:0]   opnd_a,
  input  logic [EXP_W+FRAC_W:0]   opnd_b,
  input  logic [EXP_W+FRAC_W:0]   rnd_value,
  input  logic [REM_W-1:0]        rnd_rem,
  output logic                    out_valid,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    flag_underflow,
  output logic                    flag_overflow,
  output logic                    flag_inexact,
  output logic                    flag_exception,
  output logic                    flag_invalid
);
  localparam int W      = EXP_W + FRAC_W + 1;
  localparam int N_OPND = 2;

  // Reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Operand classification
  logic [W-1:0] opnd_vec [N_OPND];
  fpx_class_t   opnd_cls [N_OPND];

  assign opnd_vec[0] = opnd_a;
  assign opnd_vec[1] = opnd_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fpx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .value (opnd_vec[g]),
      .cls   (opnd_cls[g])
    );
  end

  fpx_case_e  sel;
  fpx_flags_t nxt_flags;
  logic [W-1:0] nxt_result;
  logic nxt_inexact;

  fpx_case_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .ca      (opnd_cls[0]),
    .cb      (opnd_cls[1]),
    .op      (op_code),
    .res_mag (rnd_value[W-2:0]),
    .rem_nz  (|rnd_rem),
    .sel     (sel)
  );

  fpx_result_build #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_build (
    .sel    (sel),
    .op_lo  (op_code[1:0]),
    .rmode  (round_mode),
    .opa    (opnd_a),
    .opb    (opnd_b),
    .rnd    (rnd_value),
    .a_qnan (opnd_cls[0].qnan),
    .a_inf  (opnd_cls[0].inf),
    .res    (nxt_result),
    .flags  (nxt_flags)
  );

  always_comb nxt_inexact = |rnd_rem;

  // Output register with explicit clock enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      flag_underflow <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_inexact   <= 1'b0;
      flag_exception <= 1'b0;
      flag_invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result         <= nxt_result;
        flag_underflow <= nxt_flags.underflow;
        flag_overflow  <= nxt_flags.overflow;
        flag_inexact   <= nxt_inexact;
        flag_exception <= nxt_flags.exception;
        flag_invalid   <= nxt_flags.invalid;
      end
    end
  end
endmodule

// File: rtl/fpx_resolver_chk.sv
module fpx_resolver_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int REM_W  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] opnd_a,
  input logic [EXP_W+FRAC_W:0] opnd_b,
  input logic [REM_W-1:0]      rnd_rem,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  flag_underflow,
  input logic                  flag_overflow,
  input logic                  flag_inexact,
  input logic                  flag_exception,
  input logic                  flag_invalid
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QNAN_C =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_q, a_s, b_s;
  assign a_q = (&opnd_a[FRAC_W +: EXP_W]) & opnd_a[FRAC_W-1];
  assign a_s = (&opnd_a[FRAC_W +: EXP_W]) & ~opnd_a[FRAC_W-1] & (|opnd_a[FRAC_W-1:0]);
  assign b_s = (&opnd_b[FRAC_W +: EXP_W]) & ~opnd_b[FRAC_W-1] & (|opnd_b[FRAC_W-1:0]);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_exception))); // R1
  AST_SNAN_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_s || b_s)) |=> (result == QNAN_C && flag_invalid)); // R2
  AST_QNAN_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_q && !b_s) |=> (result == $past(opnd_a) && !flag_invalid)); // R3
  AST_INEXACT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flag_inexact == $past(|rnd_rem))); // R10
  AST_FLAGS_IMPLY_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_overflow || flag_underflow || flag_invalid) |-> flag_exception); // R7
  AST_NO_OVF_AND_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_overflow && flag_underflow)); // R8
endmodule

bind fpx_special_resolver fpx_resolver_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .REM_W(REM_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .opnd_a         (opnd_a),
  .opnd_b         (opnd_b),
  .rnd_rem        (rnd_rem),
  .out_valid      (out_valid),
  .result         (result),
  .flag_underflow (flag_underflow),
  .flag_overflow  (flag_overflow),
  .flag_inexact   (flag_inexact),
  .flag_exception (flag_exception),
  .flag_invalid   (flag_invalid)
);

// File: tb/fpx_special_resolver_test.sv
module fpx_special_resolver_test;
  localparam time CLK_P = 20ns;

  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_THR  = 64'h4008_0000_0000_0000;
  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] P_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] N_MAX  = 64'hFFEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] Q_A    = 64'h7FF8_0000_0000_1234;
  localparam logic [63:0] Q_B    = 64'hFFFC_0000_0000_0005;
  localparam logic [63:0] S_IN   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] Q_CAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] S_CAN  = 64'h7FF4_0000_0000_0000;

  // flag vector order: {underflow, overflow, inexact, exception, invalid}
  localparam logic [4:0] F_NONE = 5'b00000;
  localparam logic [4:0] F_INV  = 5'b00011;
  localparam logic [4:0] F_EXC  = 5'b00010;
  localparam logic [4:0] F_OVF  = 5'b01010;
  localparam logic [4:0] F_UNF  = 5'b10010;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [2:0] op_code;
  logic [1:0] round_mode;
  logic [63:0] opnd_a, opnd_b, rnd_value;
  logic [1:0] rnd_rem;
  logic out_valid;
  logic [63:0] result;
  logic flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  fpx_special_resolver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .round_mode(round_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .rnd_value(rnd_value), .rnd_rem(rnd_rem), .out_valid(out_valid),
    .result(result), .flag_underflow(flag_underflow),
    .flag_overflow(flag_overflow), .flag_inexact(flag_inexact),
    .flag_exception(flag_exception), .flag_invalid(flag_invalid)
  );

  function automatic logic [4:0] flags_now();
    return {flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Present one input set for one capturing edge, return at the next falling edge
  task automatic drive(input logic [2:0] op, input logic [1:0] rm,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] r, input logic [1:0] rem);
    @(negedge clk);
    op_code = op; round_mode = rm; opnd_a = a; opnd_b = b;
    rnd_value = r; rnd_rem = rem; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R13 result", result, 64'd0);
    chk("R13 flags", {59'd0, flags_now()}, {59'd0, F_NONE});
  endtask

  task automatic t_normal();
    drive(3'b000, 2'b00, P_ONE, P_TWO, P_THR, 2'b00);
    chk("R1 out_valid", {63'd0, out_valid}, 64'd1);
    chk("R11 result", result, P_THR);
    chk("R11 flags", {59'd0, flags_now()}, {59'd0, F_NONE});
    drive(3'b010, 2'b00, P_ONE, P_THR, P_THR, 2'b01);
    chk("R10 inexact no exception", {59'd0, flags_now()}, {59'd0, 5'b00100});
    drive(3'b011, 2'b00, P_ONE, P_THR, P_ONE, 2'b10);
    chk("R10 inexact upper bit", {59'd0, flags_now()}, {59'd0, 5'b00100});
  endtask

  task automatic t_hold();
    drive(3'b000, 2'b00, P_ONE, P_ONE, P_TWO, 2'b00);
    @(negedge clk);
    op_code = 3'b011; opnd_a = S_IN; opnd_b = P_ZERO; rnd_value = P_INF; rnd_rem = 2'b11;
    @(negedge clk);
    chk("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 idle result held", result, P_TWO);
    chk("R1 idle flags held", {59'd0, flags_now()}, {59'd0, F_NONE});
  endtask

  task automatic t_snan();
    drive(3'b010, 2'b00, P_ONE, S_IN, P_ONE, 2'b00);
    chk("R2 result", result, Q_CAN);
    chk("R2 flags", {59'd0, flags_now()}, {59'd0, F_INV});
    drive(3'b000, 2'b00, Q_A, S_IN, P_ONE, 2'b00);
    chk("R12 snan over qnan", result, Q_CAN);
  endtask

  task automatic t_qnan();
    drive(3'b000, 2'b00, Q_A, Q_B, P_ONE, 2'b00);
    chk("R3 A wins", result, Q_A);
    chk("R3 flags", {59'd0, flags_now()}, {59'd0, F_EXC});
    drive(3'b011, 2'b00, P_ONE, Q_B, P_ONE, 2'b00);
    chk("R3 B propagated", result, Q_B);
    drive(3'b010, 2'b00, Q_A, P_INF, P_ONE, 2'b00);
    chk("R12 qnan over inf operand", result, Q_A);
  endtask

  task automatic t_invalid();
    drive(3'b000, 2'b00, P_INF, N_INF, P_ZERO, 2'b00);
    chk("R4 inf plus -inf", result, S_CAN);
    chk("R4 flags", {59'd0, flags_now()}, {59'd0, F_INV});
    drive(3'b001, 2'b00, N_INF, N_INF, P_ZERO, 2'b00);
    chk("R4 -inf minus -inf", result, S_CAN);
    drive(3'b010, 2'b00, N_ZERO, P_INF, P_ZERO, 2'b00);
    chk("R4 zero times inf", result, S_CAN);
    drive(3'b011, 2'b00, P_ZERO, N_ZERO, P_ZERO, 2'b00);
    chk("R12 0/0 over divzero", result, S_CAN);
    drive(3'b011, 2'b00, P_INF, N_INF, P_ZERO, 2'b00);
    chk("R4 inf/inf", result, S_CAN);
    drive(3'b100, 2'b00, P_INF, N_INF, P_TWO, 2'b00);
    chk("R4 unused op passes", result, P_TWO);
    chk("R4 unused op no invalid", {59'd0, flags_now()}, {59'd0, F_NONE});
  endtask

  task automatic t_divzero();
    drive(3'b011, 2'b00, N_TWO, P_ZERO, P_ZERO, 2'b00);
    chk("R5 result", result, N_INF);
    chk("R5 flags", {59'd0, flags_now()}, {59'd0, F_EXC});
    drive(3'b011, 2'b10, N_TWO, P_ZERO, P_ZERO, 2'b00);
    chk("R9 divzero saturates", result, N_MAX);
  endtask

  task automatic t_infop();
    drive(3'b011, 2'b00, N_ONE, P_INF, P_ONE, 2'b00);
    chk("R6 finite/inf zero", result, N_ZERO);
    chk("R6 finite/inf flags", {59'd0, flags_now()}, {59'd0, F_UNF});
    drive(3'b010, 2'b00, N_INF, P_TWO, P_ONE, 2'b00);
    chk("R6 mul sign", result, N_INF);
    drive(3'b001, 2'b00, P_ONE, P_INF, P_ONE, 2'b00);
    chk("R6 sub inverts B", result, N_INF);
    drive(3'b000, 2'b00, P_ONE, N_INF, P_ONE, 2'b00);
    chk("R6 add sign B", result, N_INF);
    chk("R6 flags", {59'd0, flags_now()}, {59'd0, F_EXC});
  endtask

  task automatic t_overflow();
    drive(3'b010, 2'b00, P_MAX, P_TWO, P_INF, 2'b00);
    chk("R7 result", result, P_INF);
    chk("R7 flags", {59'd0, flags_now()}, {59'd0, F_OVF});
    drive(3'b010, 2'b01, P_MAX, P_TWO, P_INF, 2'b00);
    chk("R9 +inf toward zero", result, P_MAX);
    drive(3'b010, 2'b11, P_MAX, P_TWO, P_INF, 2'b00);
    chk("R9 +inf toward -inf", result, P_MAX);
    drive(3'b010, 2'b10, P_MAX, P_TWO, P_INF, 2'b00);
    chk("R9 +inf toward +inf kept", result, P_INF);
    drive(3'b010, 2'b10, N_MAX, P_TWO, N_INF, 2'b00);
    chk("R9 -inf toward +inf", result, N_MAX);
    drive(3'b010, 2'b11, N_MAX, P_TWO, N_INF, 2'b00);
    chk("R9 -inf toward -inf kept", result, N_INF);
    chk("R7 flags saturated", {59'd0, flags_now()}, {59'd0, F_OVF});
  endtask

  task automatic t_underflow();
    drive(3'b010, 2'b00, P_ONE, N_ONE, N_ZERO, 2'b10);
    chk("R8 result", result, N_ZERO);
    chk("R8 flags", {59'd0, flags_now()}, {59'd0, F_UNF | 5'b00100});
    drive(3'b001, 2'b00, P_ONE, P_ONE, P_ZERO, 2'b00);
    chk("R8 exact zero not underflow", {59'd0, flags_now()}, {59'd0, F_NONE});
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; round_mode = '0;
    opnd_a = '0; opnd_b = '0; rnd_value = '0; rnd_rem = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_hold();
    t_snan();
    t_qnan();
    t_invalid();
    t_divzero();
    t_infop();
    t_overflow();
    t_underflow();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule